// File: doc/BRIEF.md
# Aligned Range Invalidation Sequencer

This block turns an address span into a run of purge commands for a cache purge engine. A requester hands over a start address and an end address; the block breaks the span into naturally aligned power-of-two chunks, and for each chunk it writes a mask word and then a command word on a small register-write port. After each command it waits for the engine's busy flag to drop. A single-cycle `done` pulse marks the end of the request.

Two plain control inputs shape the request. With the cache disabled, the request finishes at once with no writes. With write-back mode on and either address off a line boundary, the block declines to invalidate and pulses `redirect` so the requester can run a flush-and-invalidate instead. In write-through mode the span is widened to whole lines first.

The request port is valid/ready. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_start`, `req_end`, `cache_en` and `wb_mode` are sampled at that edge. While a request is in progress, `req_ready` stays low. A requester that holds `req_valid` high during that time is back-pressured and is taken only after `done`.

Top module: `inv_range_seq`

## Requirements
- R1: `req_ready` is high in idle and low from the edge that accepts a request until `done` has been pulsed. It returns high in the cycle after `done`. No register write occurs while `req_ready` is high.
- R2: With `wb_mode` high and either `req_start` or `req_end` not a multiple of the line size, `redirect` and `done` pulse together and no register write occurs. This holds whatever the value of `cache_en`.
- R3: With `cache_en` low and no redirect, `done` pulses with `redirect` low and no register write occurs.
- R4: In write-through mode (`wb_mode` low), the start is rounded down to a line boundary and the end is rounded up to one. In write-back mode, aligned addresses are used unchanged.
- R5: If the (rounded) end is not above the (rounded) start, `done` pulses and no register write occurs.
- R6: The first mask write is not issued while `pe_busy` is high. The block waits for it to read low first.
- R7: Each chunk is the largest power of two that divides the current address and does not exceed the remaining length. At address zero, any power of two counts as dividing it. A span needs exactly as many chunks as that greedy rule gives.
- R8: A mask write (`reg_wr_sel` = 0) carries the bitwise NOT of (chunk size − 1). It is immediately followed in the next cycle by a command write.
- R9: A command write (`reg_wr_sel` = 1) carries the chunk's start address with bit `CMD_BIT` (0 by default) set. Chunks ascend contiguously from the rounded start to the rounded end.
- R10: After each command write, no further write occurs until `pe_busy` has been seen low. The engine raises `pe_busy` in the cycle after the command strobe.
- R11: `done` is a one-cycle pulse issued once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_start | input | AW | First byte address of the span |
| req_end | input | AW | Address one past the last byte of the span |
| cache_en | input | 1 | Cache enabled; low skips the request |
| wb_mode | input | 1 | Write-back mode; misaligned spans are redirected |
| pe_busy | input | 1 | Purge engine busy flag |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_sel | output | 1 | 0 = mask register, 1 = command register |
| reg_wr_data | output | AW | Register write data |
| done | output | 1 | One-cycle completion pulse |
| redirect | output | 1 | Span must go to flush-and-invalidate instead |

## Verification
The hardest case to reach from the ports is a request arriving while the purge engine is still busy from earlier work. In that case the block has to hold off its very first mask write. The bench reaches it by forcing the busy flag high before offering a request and holding it for several cycles. During that time it confirms that nothing is written. The chunk splitting itself is swept over every line-granular start and length in a small window, with misaligned write-through offsets, under varied busy lengths. Each command is compared against a greedy divisibility search computed in the bench.

// File: rtl/inv_seq_pkg.sv
package inv_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_MASK,
    ST_CMD,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

  localparam logic WR_SEL_MASK = 1'b0;
  localparam logic WR_SEL_CMD  = 1'b1;

endpackage

// File: rtl/inv_span_prep.sv
// Classifies an incoming span and produces its line-rounded bounds.
module inv_span_prep #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic          en_i,
  input  logic          wb_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] last_o,
  output logic          redirect_o,
  output logic          skip_o
);
  localparam int            LSH       = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] LINE_M1   = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] LINE_KEEP = ~LINE_M1;

  logic          misaligned;
  logic [AW-1:0] end_up;

  assign misaligned = (|start_i[LSH-1:0]) | (|end_i[LSH-1:0]);
  assign end_up     = (end_i + LINE_M1) & LINE_KEEP;

  // R4: write-through rounds outward, write-back keeps aligned bounds
  assign first_o    = wb_i ? start_i : (start_i & LINE_KEEP);
  assign last_o     = wb_i ? end_i : end_up;

  // R2 takes priority over the enable check
  assign redirect_o = wb_i & misaligned;
  // R3, R5
  assign skip_o     = ~redirect_o & (~en_i | (last_o <= first_o));
endmodule

// File: rtl/inv_msb_pick.sv
// Isolates the highest set bit of a word.
module inv_msb_pick #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] hi_any;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign hi_any[i] = 1'b0;
    end else begin : g_low
      assign hi_any[i] = hi_any[i+1] | x_i[i+1];
    end
    assign y_o[i] = x_i[i] & ~hi_any[i];
  end
endmodule

// File: rtl/inv_chunk_sizer.sv
// Picks the next chunk size and the mask that goes with it.
module inv_chunk_sizer #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] rem_i,
  output logic [AW-1:0] chunk_o,
  output logic [AW-1:0] mask_o
);
  logic [AW-1:0] low_bit;
  logic [AW-1:0] align_sz;
  logic [AW-1:0] rem_top;

  assign low_bit  = cur_i & (~cur_i + AW'(1));
  // at address zero the alignment limit is the whole remaining span
  assign align_sz = (cur_i == '0) ? rem_i : low_bit;

  inv_msb_pick #(.W(AW)) u_msb (
    .x_i(rem_i),
    .y_o(rem_top)
  );

  // R7
  assign chunk_o = (rem_i > align_sz) ? align_sz : rem_top;
  // R8
  assign mask_o  = ~(chunk_o - AW'(1));
endmodule

// File: rtl/inv_range_seq.sv
module inv_range_seq
  import inv_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int CMD_BIT    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  input  logic          cache_en,
  input  logic          wb_mode,
  input  logic          pe_busy,
  output logic          reg_wr_en,
  output logic          reg_wr_sel,
  output logic [AW-1:0] reg_wr_data,
  output logic          done,
  output logic          redirect
);
  localparam logic [AW-1:0] CMD_ONE = {{(AW-1){1'b0}}, 1'b1} << CMD_BIT;

  seq_state_e    state_q;
  logic [AW-1:0] cur_q, last_q, rem_q, chunk_q;
  logic          redir_q;

  logic [AW-1:0] p_first, p_last;
  logic          p_redir, p_skip;
  logic [AW-1:0] c_chunk, c_mask;
  logic [AW-1:0] next_cur;

  inv_span_prep #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_prep (
    .start_i   (req_start),
    .end_i     (req_end),
    .en_i      (cache_en),
    .wb_i      (wb_mode),
    .first_o   (p_first),
    .last_o    (p_last),
    .redirect_o(p_redir),
    .skip_o    (p_skip)
  );

  inv_chunk_sizer #(.AW(AW)) u_size (
    .cur_i  (cur_q),
    .rem_i  (rem_q),
    .chunk_o(c_chunk),
    .mask_o (c_mask)
  );

  assign next_cur = cur_q + chunk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      redir_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            redir_q <= p_redir;
            cur_q   <= p_first;
            last_q  <= p_last;
            rem_q   <= p_last - p_first;
            state_q <= (p_redir || p_skip) ? ST_FIN : ST_PRE;
          end
        end
        // R6: hold until the engine is idle
        ST_PRE:  if (!pe_busy) state_q <= ST_MASK;
        ST_MASK: begin
          chunk_q <= c_chunk;
          state_q <= ST_CMD;
        end
        ST_CMD:  state_q <= ST_WAIT;
        // R10: advance only once busy has dropped
        ST_WAIT: begin
          if (!pe_busy) begin
            cur_q   <= next_cur;
            rem_q   <= rem_q - chunk_q;
            state_q <= (next_cur < last_q) ? ST_MASK : ST_FIN;
          end
        end
        ST_FIN: begin
          redir_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign reg_wr_en   = (state_q == ST_MASK) || (state_q == ST_CMD);
  assign reg_wr_sel  = (state_q == ST_CMD) ? WR_SEL_CMD : WR_SEL_MASK;
  assign reg_wr_data = (state_q == ST_MASK) ? c_mask : (cur_q | CMD_ONE);
  assign done        = (state_q == ST_FIN);
  assign redirect    = (state_q == ST_FIN) && redir_q;
endmodule

// File: rtl/inv_range_seq_chk.sv
module inv_range_seq_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int CMD_BIT    = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          pe_busy,
  input logic          reg_wr_en,
  input logic          reg_wr_sel,
  input logic [AW-1:0] reg_wr_data,
  input logic          done,
  input logic          redirect
);
  localparam int            LSH     = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] CMD_ONE = {{(AW-1){1'b0}}, 1'b1} << CMD_BIT;

  logic mask_stb, cmd_stb;
  assign mask_stb = reg_wr_en && !reg_wr_sel;
  assign cmd_stb  = reg_wr_en && reg_wr_sel;

  a_r1_no_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !req_ready);

  a_r2_redirect_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> done);

  a_r8_mask_then_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(mask_stb));

  a_r8_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mask_stb |-> (($countones(~reg_wr_data + AW'(1)) == 1) && (reg_wr_data[LSH-1:0] == '0)));

  a_r9_cmd_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> reg_wr_data[CMD_BIT]);

  a_r9_cmd_aligned_to_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (((reg_wr_data & ~CMD_ONE) & ~$past(reg_wr_data)) == '0));

  a_r10_mask_after_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
    mask_stb |-> $past(!pe_busy));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
endmodule

bind inv_range_seq inv_range_seq_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .CMD_BIT(CMD_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .pe_busy    (pe_busy),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_sel (reg_wr_sel),
  .reg_wr_data(reg_wr_data),
  .done       (done),
  .redirect   (redirect)
);

// File: tb/sim_inv_range_seq.sv
module sim_inv_range_seq;
  localparam int LB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_start = '0;
  logic [31:0] req_end = '0;
  logic        cache_en = 1'b1;
  logic        wb_mode = 1'b0;
  logic        pe_busy;
  logic        reg_wr_en, reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        done, redirect;

  int checks = 0;
  int fails = 0;
  bit hold_busy = 1'b0;
  int busy_len = 1;
  int bcnt = 0;

  logic [31:0] exp_addr [64];
  logic [31:0] exp_size [64];
  int          exp_n;
  bit          exp_redir;
  logic [31:0] exp_last;

  always #5 clk = ~clk;

  inv_range_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .cache_en(cache_en), .wb_mode(wb_mode),
    .pe_busy(pe_busy), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .done(done), .redirect(redirect)
  );

  // engine model: busy from the cycle after a command strobe
  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else if (reg_wr_en && reg_wr_sel) bcnt <= busy_len;
    else if (bcnt != 0) bcnt <= bcnt - 1;
  end
  assign pe_busy = (bcnt != 0) || hold_busy;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic plan_req(input logic [31:0] s, input logic [31:0] e, input bit en, input bit wb);
    longint unsigned first, last, cur, p;
    bit misal;
    misal = (s % LB != 0) || (e % LB != 0);
    exp_redir = wb && misal;
    exp_n = 0;
    exp_last = '0;
    if (!exp_redir && en) begin
      first = wb ? s : (s - s % LB);
      last  = wb ? e : ((longint'(e) + LB - 1) / LB) * LB;
      exp_last = last[31:0];
      cur = first;
      while (cur < last && exp_n < 64) begin
        p = 64'd1 << 31;
        for (int k = 31; k >= 4; k--) begin
          p = 64'd1 << k;
          if (p <= last - cur && (cur % p) == 0) break;
        end
        exp_addr[exp_n] = cur[31:0];
        exp_size[exp_n] = p[31:0];
        exp_n++;
        cur += p;
      end
    end
  endtask

  task automatic run_req(input logic [31:0] s, input logic [31:0] e, input bit en,
                         input bit wb, input int blen, input int hold);
    int idx = 0;
    bit phase = 0;
    bit got_done = 0;
    string ctag;
    plan_req(s, e, en, wb);
    ctag = exp_redir ? "R2 count" : (!en ? "R3 count" : (exp_n == 0 ? "R5 count" : "R7 count"));
    @(negedge clk);
    chk(req_ready, "R1 ready in idle", {31'd0, req_ready}, 32'd1);
    busy_len  = blen;
    hold_busy = (hold > 0);
    req_valid = 1'b1; req_start = s; req_end = e; cache_en = en; wb_mode = wb;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      if (req_ready) chk(0, "R1 ready during request", 32'd1, 32'd0);
      if (c < hold) begin
        chk(!reg_wr_en, "R6 write while busy at start", {31'd0, reg_wr_en}, 32'd0);
        if (c == hold - 1) hold_busy = 1'b0;
      end
      if (reg_wr_en) begin
        if (pe_busy) chk(0, "R10 write while busy", 32'd1, 32'd0);
        if (!reg_wr_sel) begin
          chk(phase == 0 && idx < exp_n && reg_wr_data == ~(exp_size[idx] - 32'd1),
              "R8 mask", reg_wr_data, (idx < exp_n) ? ~(exp_size[idx] - 32'd1) : 32'hx);
          phase = 1;
        end else begin
          chk(phase == 1 && idx < exp_n && reg_wr_data == (exp_addr[idx] | 32'd1),
              "R9 command", reg_wr_data, (idx < exp_n) ? (exp_addr[idx] | 32'd1) : 32'hx);
          if (idx == 0 && idx < exp_n)
            chk(reg_wr_data[31:1] == exp_addr[0][31:1], "R4 rounded start",
                reg_wr_data & ~32'd1, exp_addr[0]);
          if (idx == exp_n - 1)
            chk((reg_wr_data & ~32'd1) + exp_size[idx] == exp_last, "R4 rounded end",
                (reg_wr_data & ~32'd1) + exp_size[idx], exp_last);
          idx++;
          phase = 0;
        end
      end
      if (done) begin
        chk(redirect == exp_redir, "R2 redirect flag", {31'd0, redirect}, {31'd0, exp_redir});
        chk(idx == exp_n && phase == 0, ctag, idx, exp_n);
        got_done = 1;
        break;
      end
    end
    if (!got_done) chk(0, "R11 done missing", 32'd0, 32'd1);
    hold_busy = 1'b0;
    @(negedge clk);
    chk(!done, "R11 done one cycle", {31'd0, done}, 32'd0);
    chk(req_ready, "R1 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk(!reg_wr_en && !done && !redirect, "R11 reset outputs quiet",
        {29'd0, reg_wr_en, done, redirect}, 32'd0);
    rst_n = 1'b1;
    // write-through sweep with misaligned offsets
    for (int s = 0; s < 18; s++)
      for (int l = 0; l < 18; l++)
        run_req(32'(s * LB + ((s % 3 == 1) ? 7 : 0)),
                32'(s * LB + ((s % 3 == 1) ? 7 : 0) + l * LB + ((l % 4 == 2) ? 3 : 0)),
                1'b1, 1'b0, 1 + (s + l) % 3, 0);
    // write-back aligned sweep
    for (int s = 0; s < 18; s++)
      for (int l = 0; l < 18; l++)
        run_req(32'(s * LB), 32'(s * LB + l * LB), 1'b1, 1'b1, 1 + (s * l) % 4, 0);
    // R2 redirect cases, enable irrelevant
    run_req(32'd3, 32'd64, 1'b1, 1'b1, 1, 0);
    run_req(32'd0, 32'd33, 1'b1, 1'b1, 1, 0);
    run_req(32'd48, 32'd100, 1'b0, 1'b1, 1, 0);
    // R3 disabled
    run_req(32'd0, 32'd256, 1'b0, 1'b0, 1, 0);
    run_req(32'd32, 32'd96, 1'b0, 1'b1, 1, 0);
    // R5 empty and reversed spans
    run_req(32'd256, 32'd128, 1'b1, 1'b0, 1, 0);
    run_req(32'd64, 32'd64, 1'b1, 1'b1, 1, 0);
    // R7 large and high addresses
    run_req(32'h7FFF_FFF0, 32'h8000_0100, 1'b1, 1'b0, 2, 0);
    run_req(32'hFFFF_0000, 32'hFFFF_1000, 1'b1, 1'b1, 1, 0);
    run_req(32'h0000_0000, 32'h0001_2340, 1'b1, 1'b0, 1, 0);
    run_req(32'h0012_3450, 32'h0013_0000, 1'b1, 1'b0, 3, 0);
    // R6 engine busy before the first command
    run_req(32'd0, 32'd64, 1'b1, 1'b0, 1, 6);
    run_req(32'd80, 32'd400, 1'b1, 1'b1, 2, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule